// File: doc/BRIEF.md
# Raster Fractal Frame Generator

This block produces one escape-time image per start pulse. It walks a rectangle of the complex plane in raster order and hands out whole image rows to two external iteration engines. Rows with an even index go to engine 0 and rows with an odd index go to engine 1. Each engine gets a single row-start command. The command carries the row's real start value, the per-pixel real step, the row length, the imaginary value and the iteration limit. The engine then returns one iteration count per pixel, left to right, over a valid/ready pair.

Each returned count is turned into a gray level as it arrives and stored in a one-row buffer owned by that engine. An output stage reads the buffers in strict row order and sends three bytes per pixel on a valid/ready byte stream: blue, then green, then red, all carrying the same gray value. A finished row from one engine stays in its buffer until the row before it has been fully sent. An engine gets its next row, two rows further down, only after its buffer has been drained. The default parameters size the row buffers for a 1024-pixel line, and 1024 by 768 is the intended default frame.

Top module: `frac_raster_gen`

## Requirements
- R1: A start pulse while idle latches width, height, x minimum, y maximum, dx, dy and iteration limit, and `busy` is high from the next cycle. A start pulse while busy has no effect: the frame in flight keeps its latched configuration.
- R2: Every row-start pulse on `eng_go` presents `eng_re` equal to the x minimum, `eng_dx` equal to dx, `eng_len` equal to the width and `eng_limit` equal to the latched limit.
- R3: Row r is issued to engine r mod 2 with an imaginary value of y maximum minus r times dy. An engine's row r+2 is issued only after every byte of its row r has been accepted downstream.
- R4: Output bytes leave in raster order: row 0 first, pixels left to right, three bytes per pixel in the order blue, green, red, all three equal. Pixel x of row y carries the count for real value x minimum plus x times dx.
- R5: A count greater than or equal to the iteration limit (a point that never escaped) gives a black pixel: all three bytes are 0.
- R6: Any count below the limit gives a gray value of min(count, 255).
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle.
- R8: `frame_done` is a one-cycle pulse in the cycle after the last byte of the last row is accepted. In that same cycle `busy` is low, and exactly 3 × width × height bytes have been sent.
- R9: During and right after reset, `busy`, `frame_done`, `out_valid`, `eng_go` and `eng_rdy` are all low.
- R10: `eng_go` is a one-cycle pulse. `eng_rdy` for an engine rises only with its `eng_go` and stays high until that engine has had exactly width counts accepted.
- R11: Frames of width 1 up to MAX_W, and of any height of 1 or more, including a height of 1 where engine 1 gets no row, complete with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start pulse |
| cfg_width | input | DW | Pixels per row (1..MAX_W) |
| cfg_height | input | DW | Rows per frame (at least 1) |
| cfg_xmin | input | PW | Real coordinate of the left column, signed fixed point |
| cfg_ymax | input | PW | Imaginary coordinate of the top row, signed fixed point |
| cfg_dx | input | PW | Real step per pixel |
| cfg_dy | input | PW | Imaginary step per row |
| cfg_limit | input | CW | Iteration limit |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse at frame end |
| eng_go | output | 2 | Row-start pulse per engine |
| eng_re | output | PW | Row start real value |
| eng_im | output | 2×PW | Row imaginary value per engine |
| eng_dx | output | PW | Real step per pixel |
| eng_len | output | DW | Pixels in the row |
| eng_limit | output | CW | Iteration limit |
| eng_vld | input | 2 | Count valid per engine |
| eng_cnt | input | 2×CW | Iteration count per engine |
| eng_rdy | output | 2 | Count accept per engine |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accept |
| out_data | output | 8 | Output byte |

## Verification
The hardest case to reach from the ports is a finished odd row sitting in engine 1's buffer while the even row before it is still being sent. In the same window, engine 0 must not be issued its next row early. The bench gets there with engine models that stall their count stream on a pseudo-random pattern and a downstream ready that drops on another pattern. On every row-start pulse it checks the row index against the number of bytes already accepted. A start pulse with different configuration values is also injected mid-frame, to show that the latched values rule the whole frame.

// File: rtl/frac_raster_gen.sv
module frac_raster_gen #(
  parameter int CW    = 17,
  parameter int PW    = 32,
  parameter int DW    = 11,
  parameter int MAX_W = 1024
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [DW-1:0]               cfg_width,
  input  logic [DW-1:0]               cfg_height,
  input  logic signed [PW-1:0]        cfg_xmin,
  input  logic signed [PW-1:0]        cfg_ymax,
  input  logic signed [PW-1:0]        cfg_dx,
  input  logic signed [PW-1:0]        cfg_dy,
  input  logic [CW-1:0]               cfg_limit,
  output logic                        busy,
  output logic                        frame_done,
  output logic [1:0]                  eng_go,
  output logic signed [PW-1:0]        eng_re,
  output logic [1:0][PW-1:0]          eng_im,
  output logic signed [PW-1:0]        eng_dx,
  output logic [DW-1:0]               eng_len,
  output logic [CW-1:0]               eng_limit,
  input  logic [1:0]                  eng_vld,
  input  logic [1:0][CW-1:0]          eng_cnt,
  output logic [1:0]                  eng_rdy,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [7:0]                  out_data
);
  localparam int AW = (MAX_W > 1) ? $clog2(MAX_W) : 1;

  logic                 run;
  logic [DW-1:0]        w_q, h_q;
  logic signed [PW-1:0] xmin_q, dx_q, dy_q;
  logic [CW-1:0]        lim_q;
  logic [DW:0]          crow;
  logic [AW-1:0]        ridx;
  logic [1:0]           ph;
  logic [1:0]           full;
  logic [7:0]           rbyte [2];

  wire kick      = start && !run;
  wire par       = crow[0];
  wire fire      = out_valid && out_ready;
  wire last_px   = ridx == AW'(w_q - 1'b1);
  wire row_end   = fire && (ph == 2'd2) && last_px;
  wire frame_end = row_end && (crow == {1'b0, h_q} - 1'b1);

  assign busy      = run;
  assign out_valid = run && full[par];
  assign out_data  = rbyte[par];
  assign eng_re    = xmin_q;
  assign eng_dx    = dx_q;
  assign eng_len   = w_q;
  assign eng_limit = lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      frame_done <= 1'b0;
      w_q        <= '0;
      h_q        <= '0;
      xmin_q     <= '0;
      dx_q       <= '0;
      dy_q       <= '0;
      lim_q      <= '0;
      crow       <= '0;
      ridx       <= '0;
      ph         <= '0;
    end else begin
      frame_done <= frame_end;
      if (kick) begin
        run    <= 1'b1;
        w_q    <= cfg_width;
        h_q    <= cfg_height;
        xmin_q <= cfg_xmin;
        dx_q   <= cfg_dx;
        dy_q   <= cfg_dy;
        lim_q  <= cfg_limit;
        crow   <= '0;
        ridx   <= '0;
        ph     <= '0;
      end else if (fire) begin
        if (ph == 2'd2) begin
          ph <= '0;
          if (last_px) begin
            ridx <= '0;
            crow <= crow + 1'b1;
            if (frame_end) run <= 1'b0;
          end else begin
            ridx <= ridx + 1'b1;
          end
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  for (genvar e = 0; e < 2; e++) begin : g_eng
    logic [DW:0]          row_q;
    logic signed [PW-1:0] im_q;
    logic [AW-1:0]        widx;
    logic                 bsy_q, full_q, go_q;
    logic [7:0]           mem [MAX_W];

    wire [CW-1:0] c     = eng_cnt[e];
    wire [7:0]    g     = (c >= lim_q) ? 8'd0 : (c > CW'(255)) ? 8'hFF : c[7:0];
    wire          take  = eng_vld[e] && bsy_q;
    wire          issue = run && !bsy_q && !full_q && (row_q < {1'b0, h_q});
    wire          drain = row_end && (par == 1'(e));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        row_q  <= '0;
        im_q   <= '0;
        widx   <= '0;
        bsy_q  <= 1'b0;
        full_q <= 1'b0;
        go_q   <= 1'b0;
      end else if (kick) begin
        row_q  <= (DW+1)'(e);
        im_q   <= cfg_ymax - ((e == 1) ? cfg_dy : '0);
        widx   <= '0;
        bsy_q  <= 1'b0;
        full_q <= 1'b0;
        go_q   <= 1'b0;
      end else begin
        go_q <= issue;
        if (issue) begin
          bsy_q <= 1'b1;
          widx  <= '0;
        end else if (take) begin
          if (widx == AW'(w_q - 1'b1)) begin
            bsy_q  <= 1'b0;
            full_q <= 1'b1;
            row_q  <= row_q + (DW+1)'(2);
            im_q   <= im_q - (dy_q <<< 1);
          end else begin
            widx <= widx + 1'b1;
          end
        end
        if (drain) full_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (take) mem[widx] <= g;
    end

    assign rbyte[e]   = mem[ridx];
    assign full[e]    = full_q;
    assign eng_go[e]  = go_q;
    assign eng_rdy[e] = bsy_q;
    assign eng_im[e]  = im_q;
  end
endmodule

// File: rtl/frac_raster_gen_chk.sv
module frac_raster_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       frame_done,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [1:0] eng_go,
  input logic [1:0] eng_rdy
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(out_valid && out_ready) && !busy);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && (eng_go == 2'b00) && (eng_rdy == 2'b00));

  assert_rdy_rise0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rdy[0]) |-> eng_go[0]);

  assert_rdy_rise1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_rdy[1]) |-> eng_go[1]);

  assert_go_single0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go[0] |=> !eng_go[0]);

  assert_go_single1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go[1] |=> !eng_go[1]);
endmodule

bind frac_raster_gen frac_raster_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .frame_done(frame_done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .eng_go(eng_go), .eng_rdy(eng_rdy)
);

// File: tb/frac_raster_gen_tb.sv
module frac_raster_gen_tb;
  localparam int CLK_NS = 10;
  localparam int CW = 17;
  localparam int PW = 32;
  localparam int DW = 11;
  localparam int MAX_W = 1024;
  localparam int NV = 6;
  // width, height, xmin, ymax, dx, dy, limit, ready mode
  localparam int VEC [NV][8] = '{
    '{5,    4,  5,   1000, 7,  13, 300,  0},
    '{1,    1,  -20, 40,   3,  9,  300,  1},
    '{7,    3,  100, -50,  11, 17, 5,    1},
    '{16,   2,  0,   600,  40, 3,  1000, 1},
    '{3,    5,  -7,  9,    2,  1,  260,  0},
    '{1024, 2,  1,   2,    1,  1,  400,  1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DW-1:0] cfg_width = '0, cfg_height = '0;
  logic signed [PW-1:0] cfg_xmin = '0, cfg_ymax = '0, cfg_dx = '0, cfg_dy = '0;
  logic [CW-1:0] cfg_limit = '0;
  logic busy, frame_done, out_valid, out_ready = 1'b0;
  logic [7:0] out_data;
  logic [1:0] eng_go, eng_rdy, eng_vld = '0;
  logic signed [PW-1:0] eng_re, eng_dx;
  logic [1:0][PW-1:0] eng_im;
  logic [DW-1:0] eng_len;
  logic [CW-1:0] eng_limit;
  logic [1:0][CW-1:0] eng_cnt = '0;

  frac_raster_gen u_dut (.*);

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cw, ch, cx, cy, cdx, cdy, cl, rmode;
  int nbytes = 0, dones = 0;
  int gocnt [2];
  bit act [2], pend [2];
  int mre [2], mim [2], mdx [2], mlen [2], idx [2];
  logic [15:0] lfsr = 16'hACE1;
  bit pv = 0, pr = 0;
  logic [7:0] pd = '0;

  function automatic int fcnt(int re, int im);
    return ((re * 3 + im) & 32'h7fffffff) % (cl + 1);
  endfunction

  function automatic int gray(int c);
    if (c >= cl) return 0;
    if (c > 255) return 255;
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  // downstream consumer
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      pv = 0; pr = 0;
    end else begin
      if (pv && !pr) chk(out_valid && out_data == pd, "R7 hold", int'(out_data), int'(pd));
      out_ready = (rmode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      if (out_valid && out_ready) begin
        int pix, x, y, c, e;
        pix = nbytes / 3; x = pix % cw; y = pix / cw;
        c = fcnt(cx + x * cdx, cy - y * cdy);
        e = gray(c);
        if (c >= cl)      chk(out_data == 8'(e), "R5 black", int'(out_data), e);
        else if (c > 255) chk(out_data == 8'(e), "R6 saturate", int'(out_data), e);
        else              chk(out_data == 8'(e), "R4 raster byte", int'(out_data), e);
        nbytes++;
      end
      if (frame_done) begin
        dones++;
        chk(nbytes == 3 * cw * ch, "R8 byte total", nbytes, 3 * cw * ch);
        chk(!busy, "R8 busy low", int'(busy), 0);
      end
      pv = out_valid; pr = out_ready; pd = out_data;
    end
  end

  // iteration engine stand-ins
  always @(negedge clk) begin
    for (int e = 0; e < 2; e++) begin
      if (!rst_n) begin
        act[e] = 0; pend[e] = 0; eng_vld[e] = 1'b0;
      end else begin
        if (pend[e]) begin
          pend[e] = 0; idx[e]++; mre[e] += mdx[e];
          if (idx[e] == mlen[e]) act[e] = 0;
        end
        if (eng_go[e]) begin
          int row;
          row = 2 * gocnt[e] + e;
          gocnt[e]++;
          chk(eng_re == cx, "R2 re", int'(eng_re), cx);
          chk(eng_dx == cdx, "R2 dx", int'(eng_dx), cdx);
          chk(int'(eng_len) == cw, "R2 len", int'(eng_len), cw);
          chk(int'(eng_limit) == cl, "R2 limit", int'(eng_limit), cl);
          chk(int'($signed(eng_im[e])) == cy - row * cdy, "R3 im", int'($signed(eng_im[e])), cy - row * cdy);
          chk(row < ch, "R3 row range", row, ch - 1);
          chk(row < 2 || nbytes >= 3 * cw * (row - 1), "R3 order", nbytes, 3 * cw * (row - 1));
          act[e] = 1; idx[e] = 0; mre[e] = int'(eng_re);
          mim[e] = int'($signed(eng_im[e])); mdx[e] = int'(eng_dx); mlen[e] = int'(eng_len);
        end
        if (act[e] || eng_rdy[e]) chk(eng_rdy[e] == act[e], "R10 rdy window", int'(eng_rdy[e]), int'(act[e]));
        eng_vld[e] = act[e] && (lfsr[e+1] | lfsr[e+5]);
        eng_cnt[e] = CW'(fcnt(mre[e], mim[e]));
        pend[e] = eng_vld[e] && eng_rdy[e];
      end
    end
  end

  task automatic run_frame(int w, int h, int x, int y, int dx, int dy, int l, int rm, bit poke);
    int d0, t;
    cw = w; ch = h; cx = x; cy = y; cdx = dx; cdy = dy; cl = l; rmode = rm;
    nbytes = 0; gocnt[0] = 0; gocnt[1] = 0; d0 = dones;
    @(negedge clk);
    cfg_width = DW'(w); cfg_height = DW'(h); cfg_xmin = x; cfg_ymax = y;
    cfg_dx = dx; cfg_dy = dy; cfg_limit = CW'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R1 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (25) @(negedge clk);
      cfg_width = DW'(w + 2); cfg_height = DW'(h + 1); cfg_xmin = x + 50;
      cfg_ymax = y - 9; cfg_dx = dx + 1; cfg_dy = dy + 3; cfg_limit = CW'(l + 7);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R1 start ignored", int'(busy), 1);
    end
    t = 0;
    while (dones == d0 && t < 50000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 50000, "R8 frame end seen", t, 50000);
    chk(nbytes == 3 * w * h, "R11 frame bytes", nbytes, 3 * w * h);
    @(negedge clk);
  endtask

  initial begin
    cw = 1; ch = 1; cx = 0; cy = 0; cdx = 0; cdy = 0; cl = 1; rmode = 0;
    gocnt[0] = 0; gocnt[1] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !frame_done && eng_go == 2'b00 && eng_rdy == 2'b00,
        "R9 in reset", int'({busy, out_valid, frame_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !frame_done && eng_go == 2'b00 && eng_rdy == 2'b00,
        "R9 after reset", int'({busy, out_valid, frame_done}), 0);
    for (int i = 0; i < NV; i++)
      run_frame(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], VEC[i][6], VEC[i][7], 1'b0);
    // mid-frame start with changed configuration (R1)
    run_frame(6, 4, 3, 70, 5, 4, 280, 1, 1'b1);
    // height 1 with a wide row and a tiny limit (R11, R5)
    run_frame(9, 1, 2, 3, 1, 1, 2, 1, 1'b0);
    repeat (5) @(negedge clk);
    chk(!busy && !out_valid && eng_rdy == 2'b00, "R9 idle after frames", int'({busy, out_valid}), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog R8 actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule